// File: doc/BRIEF.md
# Infrared RC-6 Frame Receiver

This block takes one demodulated infrared data line and turns the RC-6 frames on it into parallel fields. It brings the line into the local clock domain and measures the gaps between edges in protocol half-bit units. It recognises the leader, then reads the Manchester symbols that follow, including the double-width toggle symbol. When the line has stayed quiet long enough to end the frame, it emits a one-cycle strobe with the mode, the toggle, the address, the data word and the data length.

The line polarity comes from a two-bit configuration input. It can be fixed either way, or taken from the line itself when the leader ends. The length of a half-bit, in clock cycles, is a parameter. For a 50 MHz clock it is 22225. A bench can set it much lower.

The layout of a frame depends on the mode it carries. Mode 0 frames have a fixed length. Mode 6 frames have either a short or a long address, chosen by the first address bit, followed by a data field of any length up to the limit. A frame of any other shape is dropped without a strobe.

Top module: `rc6_rx`

## Requirements
- R1: Every edge gap is rounded to the nearest whole half-bit unit of HALF_CYCLES clocks. A gap that is off by up to a quarter unit decodes the same as an exact one.
- R2: A frame begins only at an edge that closes a 2-unit space gap directly after a 6-unit mark gap. Any other lead-in produces no strobe.
- R3: polSel 2'b00 takes the mark level from the line at the end of the leader. 2'b01 fixes mark as low and 2'b1x fixes mark as high. With a fixed polarity, a leader at the opposite level starts no frame.
- R4: A data bit of value 1 is a mark half followed by a space half, and a 0 is space then mark. The fifth symbol after the leader is the toggle. It lasts four half units: two of one level, then two of the other.
- R5: The first symbol after the leader is the start bit. If it decodes as 0, the frame is dropped.
- R6: The next three bits are the mode, MSB first, and then the toggle. In mode 0, the frame must carry exactly 16 further bits. These give an 8-bit address and then an 8-bit data word, MSB first, with frameDataLen = 8 and frameLongAddr = 0. Any other count is dropped.
- R7: In mode 6, if the first bit after the toggle is 0 and at least 9 bits follow the toggle, the first 8 of them are the address. The rest are the data, and frameDataLen is the number of data bits.
- R8: In mode 6, if the first bit after the toggle is 1 and at least 17 bits follow the toggle, the first 16 are the address and frameLongAddr = 1. A frame with a long address and fewer bits is dropped.
- R9: Frames in any mode other than 0 or 6 are dropped. So are frames whose data field would exceed 32 bits.
- R10: During a frame, an edge gap of 0, 4 or 5 units, or a symbol without a mid-bit transition, drops the frame. The next proper leader is decoded normally.
- R11: A frame ends once 6.5 units have passed without an edge. frameValid is then high for exactly one cycle. The output fields change only with that strobe and hold their values in between.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irIn | input | 1 | Demodulated infrared line (asynchronous) |
| polSel | input | 2 | Polarity select: 00 automatic, 01 mark low, 1x mark high |
| frameValid | output | 1 | One-cycle strobe for a decoded frame |
| frameMode | output | 3 | Mode field |
| frameToggle | output | 1 | Toggle bit |
| frameLongAddr | output | 1 | Set when the address is 16 bits wide |
| frameAddr | output | 16 | Address, right-aligned |
| frameData | output | 32 | Data field, right-aligned |
| frameDataLen | output | 6 | Number of valid data bits |

## Verification
A drift in the half-unit grid, or a lost symbol boundary, shows up one symbol later. Every later bit is then misread, so the address and data of that same frame are wrong, or the frame is dropped and no strobe appears. A wrong header count shows at the strobe as a shifted address/data split or a changed data length. A wrong end-of-frame state shows as a missing strobe, a repeated strobe, or fields that change between strobes. The bench drives whole frames with and without timing skew, in both polarities and every layout. It compares each strobe against the fields it sent, and it counts strobes to catch frames that should have been dropped.

// File: rtl/rc6_pkg.sv
package rc6_pkg;
  localparam int HDR_N = 5;  // start, three mode bits, toggle

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_TAIL = 2'd2
  } rxState_e;

  typedef struct packed {
    logic startFrame;
    logic pushBit;
    logic bitVal;
    logic finishFrame;
  } ctrlStrobe_t;
endpackage

// File: rtl/rc6_datapath.sv
module rc6_datapath
  import rc6_pkg::*;
#(
  parameter int HALF_CYCLES = 22225,
  parameter int ADDR_MAX    = 16,
  parameter int DATA_MAX    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          irIn,
  input  ctrlStrobe_t                   strb,
  output logic                          edgeSeen,
  output logic                          tick,
  output logic                          lineLvl,
  output logic [2:0]                    units,
  output logic [2:0]                    prevUnits,
  output logic [$clog2(HDR_N+ADDR_MAX+DATA_MAX+1)-1:0] bitCount,
  output logic                          frameValid,
  output logic [2:0]                    frameMode,
  output logic                          frameToggle,
  output logic                          frameLongAddr,
  output logic [ADDR_MAX-1:0]           frameAddr,
  output logic [DATA_MAX-1:0]           frameData,
  output logic [$clog2(DATA_MAX+1)-1:0] frameDataLen
);
  localparam int PH_W    = $clog2(HALF_CYCLES);
  localparam int MID     = HALF_CYCLES / 2 - 1;
  localparam int PAY_W   = ADDR_MAX + DATA_MAX;
  localparam int CNT_W   = $clog2(HDR_N + PAY_W + 1);
  localparam int IDX_W   = $clog2(PAY_W);
  localparam int LEN_W   = $clog2(DATA_MAX + 1);
  localparam int SHORT_A = ADDR_MAX / 2;

  // two-flop synchroniser plus one history flop for edge detection
  logic [2:0]       syncQ;
  logic [PH_W-1:0]  phase;
  logic [HDR_N-1:0] hdr;
  logic [PAY_W-1:0] pay;

  assign lineLvl  = syncQ[1];
  assign edgeSeen = syncQ[1] ^ syncQ[2];
  assign tick     = !edgeSeen && (phase == PH_W'(MID));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      phase     <= '0;
      units     <= 3'd7;
      prevUnits <= 3'd7;
    end else begin
      syncQ <= {syncQ[1:0], irIn};
      if (edgeSeen) begin
        phase     <= '0;
        units     <= '0;
        prevUnits <= units;
      end else begin
        phase <= (phase == PH_W'(HALF_CYCLES - 1)) ? '0 : phase + 1'b1;
        if (tick && units != 3'd7) units <= units + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdr      <= '0;
      pay      <= '0;
      bitCount <= '0;
    end else if (strb.startFrame) begin
      hdr      <= '0;
      pay      <= '0;
      bitCount <= '0;
    end else if (strb.pushBit) begin
      if (bitCount < CNT_W'(HDR_N)) hdr <= {hdr[HDR_N-2:0], strb.bitVal};
      else                          pay <= {pay[PAY_W-2:0], strb.bitVal};
      bitCount <= bitCount + 1'b1;
    end
  end

  // field extraction for the frame in the shift registers
  logic [CNT_W-1:0] payN, dLen;
  logic [IDX_W-1:0] firstIdx;
  logic             firstBit, okFrame, longA;
  logic [PAY_W-1:0] addrShift, dataMask;

  always_comb begin
    payN     = bitCount - CNT_W'(HDR_N);
    firstIdx = IDX_W'(payN - 1'b1);
    firstBit = (payN != '0) ? pay[firstIdx] : 1'b0;
    okFrame  = 1'b0;
    longA    = 1'b0;
    dLen     = '0;
    if (bitCount >= CNT_W'(HDR_N) && hdr[HDR_N-1]) begin
      if (hdr[3:1] == 3'd0) begin
        okFrame = (payN == CNT_W'(2 * SHORT_A));
        dLen    = CNT_W'(SHORT_A);
      end else if (hdr[3:1] == 3'd6) begin
        if (!firstBit && payN > CNT_W'(SHORT_A)) begin
          okFrame = 1'b1;
          dLen    = payN - CNT_W'(SHORT_A);
        end else if (firstBit && payN > CNT_W'(ADDR_MAX)) begin
          okFrame = 1'b1;
          longA   = 1'b1;
          dLen    = payN - CNT_W'(ADDR_MAX);
        end
      end
      if (dLen > CNT_W'(DATA_MAX)) okFrame = 1'b0;
    end
    addrShift = pay >> dLen;
    dataMask  = ~({PAY_W{1'b1}} << dLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameValid    <= 1'b0;
      frameMode     <= '0;
      frameToggle   <= 1'b0;
      frameLongAddr <= 1'b0;
      frameAddr     <= '0;
      frameData     <= '0;
      frameDataLen  <= '0;
    end else begin
      frameValid <= strb.finishFrame && okFrame;
      if (strb.finishFrame && okFrame) begin
        frameMode     <= hdr[3:1];
        frameToggle   <= hdr[0];
        frameLongAddr <= longA;
        frameAddr     <= longA ? addrShift[ADDR_MAX-1:0]
                               : {{(ADDR_MAX-SHORT_A){1'b0}}, addrShift[SHORT_A-1:0]};
        frameData     <= DATA_MAX'(pay & dataMask);
        frameDataLen  <= LEN_W'(dLen);
      end
    end
  end
endmodule

// File: rtl/rc6_ctrl.sv
module rc6_ctrl
  import rc6_pkg::*;
#(
  parameter int PAY_W = 48,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       polSel,
  input  logic             edgeSeen,
  input  logic             tick,
  input  logic             lineLvl,
  input  logic [2:0]       units,
  input  logic [2:0]       prevUnits,
  input  logic [CNT_W-1:0] bitCount,
  output ctrlStrobe_t      strb
);
  rxState_e   st;
  logic       markLvl;
  logic [1:0] halfIdx;
  logic [2:0] halves;

  logic levelOk, leaderHit, isMark, wide, lastHalf, timeout, goodGap;
  logic spaceOnly, legal, val, startBad, full, symDone;

  always_comb begin
    levelOk   = (polSel == 2'b00) || (lineLvl == polSel[1]);
    leaderHit = edgeSeen && prevUnits == 3'd6 && units == 3'd2 && levelOk;
    isMark    = (lineLvl == markLvl);
    wide      = (bitCount == CNT_W'(HDR_N - 1));
    lastHalf  = wide ? (halfIdx == 2'd3) : (halfIdx == 2'd1);
    timeout   = tick && units == 3'd6;
    goodGap   = units inside {3'd1, 3'd2, 3'd3, 3'd6};
    if (wide) begin
      spaceOnly = !halves[2] && !halves[1] && !halves[0] && !isMark;
      legal     = (halves[2] == halves[1]) && (halves[0] == isMark) && (halves[1] != halves[0]);
      val       = halves[2];
    end else begin
      spaceOnly = !halves[0] && !isMark;
      legal     = halves[0] != isMark;
      val       = halves[0];
    end
    startBad = (bitCount == '0) && !val;
    full     = (bitCount == CNT_W'(HDR_N + PAY_W));
    symDone  = !leaderHit && st == ST_DATA && tick && !timeout && lastHalf;

    strb.startFrame  = leaderHit;
    strb.pushBit     = symDone && !spaceOnly && legal && !startBad && !full;
    strb.bitVal      = val;
    strb.finishFrame = !leaderHit && st != ST_IDLE && timeout;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      markLvl <= 1'b0;
      halfIdx <= '0;
      halves  <= '0;
    end else if (leaderHit) begin
      st      <= ST_DATA;
      markLvl <= (polSel == 2'b00) ? lineLvl : polSel[1];
      halfIdx <= '0;
    end else begin
      unique case (st)
        ST_DATA: begin
          if (edgeSeen && !goodGap) st <= ST_IDLE;
          else if (timeout)         st <= ST_IDLE;
          else if (tick) begin
            halves <= {halves[1:0], isMark};
            if (lastHalf) begin
              halfIdx <= '0;
              if (spaceOnly)                    st <= ST_TAIL;
              else if (!legal || startBad || full) st <= ST_IDLE;
            end else begin
              halfIdx <= halfIdx + 2'd1;
            end
          end
        end
        ST_TAIL: if (edgeSeen || timeout) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rc6_rx.sv
module rc6_rx
  import rc6_pkg::*;
#(
  parameter int HALF_CYCLES = 22225,
  parameter int ADDR_MAX    = 16,
  parameter int DATA_MAX    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          irIn,
  input  logic [1:0]                    polSel,
  output logic                          frameValid,
  output logic [2:0]                    frameMode,
  output logic                          frameToggle,
  output logic                          frameLongAddr,
  output logic [ADDR_MAX-1:0]           frameAddr,
  output logic [DATA_MAX-1:0]           frameData,
  output logic [$clog2(DATA_MAX+1)-1:0] frameDataLen
);
  localparam int PAY_W = ADDR_MAX + DATA_MAX;
  localparam int CNT_W = $clog2(HDR_N + PAY_W + 1);

  ctrlStrobe_t      strb;
  logic             edgeSeen, tick, lineLvl;
  logic [2:0]       units, prevUnits;
  logic [CNT_W-1:0] bitCount;

  rc6_datapath #(.HALF_CYCLES(HALF_CYCLES), .ADDR_MAX(ADDR_MAX), .DATA_MAX(DATA_MAX)) uPath (
    .clk(clk), .rstN(rstN), .irIn(irIn), .strb(strb),
    .edgeSeen(edgeSeen), .tick(tick), .lineLvl(lineLvl),
    .units(units), .prevUnits(prevUnits), .bitCount(bitCount),
    .frameValid(frameValid), .frameMode(frameMode), .frameToggle(frameToggle),
    .frameLongAddr(frameLongAddr), .frameAddr(frameAddr), .frameData(frameData),
    .frameDataLen(frameDataLen)
  );

  rc6_ctrl #(.PAY_W(PAY_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .polSel(polSel), .edgeSeen(edgeSeen), .tick(tick),
    .lineLvl(lineLvl), .units(units), .prevUnits(prevUnits), .bitCount(bitCount),
    .strb(strb)
  );
endmodule

// File: rtl/rc6_rx_checker.sv
module rc6_rx_checker #(
  parameter int ADDR_MAX = 16,
  parameter int DATA_MAX = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          frameValid,
  input logic [2:0]                    frameMode,
  input logic                          frameLongAddr,
  input logic [ADDR_MAX-1:0]           frameAddr,
  input logic [DATA_MAX-1:0]           frameData,
  input logic [$clog2(DATA_MAX+1)-1:0] frameDataLen
);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  a_r11_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> ($stable(frameData) && $stable(frameAddr) && $stable(frameDataLen)));

  a_r8_long_only_mode6: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameLongAddr) |-> frameMode == 3'd6);

  a_r6_mode0_shape: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameMode == 3'd0) |-> (frameDataLen == 8 && !frameLongAddr));

  a_r9_len_range: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> (frameDataLen != 0 && frameDataLen <= DATA_MAX
                    && (frameMode == 3'd0 || frameMode == 3'd6)));

  a_r7_short_addr_width: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !frameLongAddr) |-> (frameAddr >> (ADDR_MAX / 2)) == 0);
endmodule

bind rc6_rx rc6_rx_checker #(.ADDR_MAX(ADDR_MAX), .DATA_MAX(DATA_MAX)) chk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameMode(frameMode),
  .frameLongAddr(frameLongAddr), .frameAddr(frameAddr), .frameData(frameData),
  .frameDataLen(frameDataLen)
);

// File: tb/tb_rc6_rx.sv
module tb_rc6_rx;
  localparam int HALF = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irIn = 1'b0;
  logic [1:0]  polSel = 2'b00;
  logic        frameValid, frameToggle, frameLongAddr;
  logic [2:0]  frameMode;
  logic [15:0] frameAddr;
  logic [31:0] frameData;
  logic [5:0]  frameDataLen;

  always #10 clk = ~clk;  // 50 MHz

  rc6_rx #(.HALF_CYCLES(HALF)) dut (
    .clk(clk), .rstN(rstN), .irIn(irIn), .polSel(polSel),
    .frameValid(frameValid), .frameMode(frameMode), .frameToggle(frameToggle),
    .frameLongAddr(frameLongAddr), .frameAddr(frameAddr), .frameData(frameData),
    .frameDataLen(frameDataLen)
  );

  int nChecks = 0, nFail = 0, pulses = 0, widePulse = 0;
  logic lastValid = 1'b0;
  logic        curMk = 1'b0;
  int          curSkew = 0;

  always @(negedge clk) begin
    if (frameValid) begin
      pulses++;
      if (lastValid) widePulse++;
    end
    lastValid = frameValid;
  end

  task automatic check(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic seg(input logic isM, input int n);
    irIn = isM ? curMk : ~curMk;
    repeat (n * HALF + (isM ? curSkew : -curSkew)) @(negedge clk);
  endtask

  task automatic sendBit(input logic v);
    if (v) begin seg(1'b1, 1); seg(1'b0, 1); end
    else   begin seg(1'b0, 1); seg(1'b1, 1); end
  endtask

  task automatic sendFrame(input int leadMark, input logic [2:0] mode, input logic tog,
                           input logic st, input int nPay, input logic [47:0] pay);
    seg(1'b0, 8);
    seg(1'b1, leadMark);
    seg(1'b0, 2);
    sendBit(st);
    for (int i = 2; i >= 0; i--) sendBit(mode[i]);
    if (tog) begin seg(1'b1, 2); seg(1'b0, 2); end
    else     begin seg(1'b0, 2); seg(1'b1, 2); end
    for (int i = nPay - 1; i >= 0; i--) sendBit(pay[i]);
    seg(1'b0, 12);
  endtask

  typedef struct packed {
    logic        mk;
    logic [1:0]  pol;
    logic [1:0]  skew;
    logic [2:0]  mode;
    logic        tog;
    logic [5:0]  nPay;
    logic [47:0] pay;
    logic        expValid;
    logic        expLong;
    logic [15:0] expAddr;
    logic [31:0] expData;
    logic [5:0]  expLen;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 2'd0, 3'd0, 1'b0, 6'd16, 48'h5AC3,            1'b1, 1'b0, 16'h5A,   32'hC3,       6'd8},
    '{1'b1, 2'd2, 2'd2, 3'd0, 1'b1, 6'd16, 48'h01FF,            1'b1, 1'b0, 16'h01,   32'hFF,       6'd8},
    '{1'b1, 2'd0, 2'd0, 3'd6, 1'b1, 6'd28, 48'h35ABCDE,         1'b1, 1'b0, 16'h35,   32'hABCDE,    6'd20},
    '{1'b0, 2'd1, 2'd2, 3'd6, 1'b0, 6'd48, 48'h8421DEADBEEF,    1'b1, 1'b1, 16'h8421, 32'hDEADBEEF, 6'd32},
    '{1'b1, 2'd2, 2'd0, 3'd6, 1'b0, 6'd17, 48'h1FFFF,           1'b1, 1'b1, 16'hFFFF, 32'h1,        6'd1},
    '{1'b0, 2'd0, 2'd0, 3'd6, 1'b1, 6'd9,  48'h0FC,             1'b1, 1'b0, 16'h7E,   32'h0,        6'd1},
    '{1'b0, 2'd0, 2'd0, 3'd3, 1'b0, 6'd16, 48'h1234,            1'b0, 1'b0, 16'h0,    32'h0,        6'd0},
    '{1'b0, 2'd0, 2'd0, 3'd0, 1'b0, 6'd17, 48'h12345,           1'b0, 1'b0, 16'h0,    32'h0,        6'd0},
    '{1'b1, 2'd0, 2'd0, 3'd6, 1'b0, 6'd41, 48'h0123456789A,     1'b0, 1'b0, 16'h0,    32'h0,        6'd0},
    '{1'b1, 2'd0, 2'd0, 3'd6, 1'b0, 6'd16, 48'hF00F,            1'b0, 1'b0, 16'h0,    32'h0,        6'd0},
    '{1'b0, 2'd2, 2'd0, 3'd0, 1'b0, 6'd16, 48'h5AC3,            1'b0, 1'b0, 16'h0,    32'h0,        6'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset state
    check(frameValid == 0 && frameMode == 0 && frameToggle == 0 && frameLongAddr == 0 &&
          frameAddr == 0 && frameData == 0 && frameDataLen == 0, "R12 reset outputs",
          {frameAddr, frameData}, 48'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R1 skew, R3 polarity, R4 toggle, R6 R7 R8 R9 layouts
    for (int v = 0; v < NV; v++) begin
      curMk = VECS[v].mk;
      curSkew = int'(VECS[v].skew);
      polSel = VECS[v].pol;
      pulses = 0;
      sendFrame(6, VECS[v].mode, VECS[v].tog, 1'b1, int'(VECS[v].nPay), VECS[v].pay);
      check(pulses == int'(VECS[v].expValid), $sformatf("R1 R3 R9 strobe count vec %0d", v),
            48'(pulses), 48'(VECS[v].expValid));
      if (VECS[v].expValid) begin
        check(frameMode == VECS[v].mode && frameToggle == VECS[v].tog,
              $sformatf("R4 R6 mode/toggle vec %0d", v),
              {44'h0, frameMode, frameToggle}, {44'h0, VECS[v].mode, VECS[v].tog});
        check(frameAddr == VECS[v].expAddr && frameLongAddr == VECS[v].expLong,
              $sformatf("R7 R8 address vec %0d", v),
              {31'h0, frameLongAddr, frameAddr}, {31'h0, VECS[v].expLong, VECS[v].expAddr});
        check(frameData == VECS[v].expData && frameDataLen == VECS[v].expLen,
              $sformatf("R6 R7 R8 data vec %0d", v),
              {10'h0, frameDataLen, frameData}, {10'h0, VECS[v].expLen, VECS[v].expData});
      end
    end

    // R11: fields held from last good frame (vec 5) across dropped ones
    check(frameAddr == 16'h7E && frameData == 32'h0 && frameDataLen == 6'd1,
          "R11 fields held", {frameAddr, frameData}, {16'h7E, 32'h0});
    check(widePulse == 0, "R11 strobe width one cycle", 48'(widePulse), 48'h0);

    curMk = 1'b0; curSkew = 0; polSel = 2'b00;

    // R5: start bit 0 dropped
    pulses = 0;
    sendFrame(6, 3'd0, 1'b0, 1'b0, 16, 48'h5AC3);
    check(pulses == 0, "R5 start bit zero dropped", 48'(pulses), 48'h0);

    // R2: leader of 5 units is not a leader
    pulses = 0;
    sendFrame(5, 3'd0, 1'b0, 1'b1, 16, 48'h5AC3);
    check(pulses == 0, "R2 short leader ignored", 48'(pulses), 48'h0);

    // R10: 4-unit mark inside a frame aborts it
    pulses = 0;
    seg(1'b0, 8); seg(1'b1, 6); seg(1'b0, 2);
    sendBit(1'b1); sendBit(1'b0);
    seg(1'b1, 4); seg(1'b0, 12);
    check(pulses == 0, "R10 illegal gap dropped", 48'(pulses), 48'h0);

    // R10: recovery on the next proper frame
    pulses = 0;
    sendFrame(6, 3'd0, 1'b1, 1'b1, 16, 48'hA55A);
    check(pulses == 1 && frameAddr == 16'hA5 && frameData == 32'h5A && frameToggle == 1'b1,
          "R10 recovery frame", {frameAddr, frameData}, {16'hA5, 32'h5A});

    // R11: strobe only after quiet time: frame ending in a 1 bit, check near end
    pulses = 0;
    seg(1'b0, 8); seg(1'b1, 6); seg(1'b0, 2);
    sendBit(1'b1);
    for (int i = 2; i >= 0; i--) sendBit(1'b0);
    seg(1'b0, 2); seg(1'b1, 2);
    for (int i = 15; i >= 1; i--) sendBit(1'b0);
    seg(1'b1, 1);              // last bit 1: mark half, then space from here on
    irIn = ~curMk;
    repeat (5 * HALF) @(negedge clk);
    check(pulses == 0, "R11 no strobe before timeout", 48'(pulses), 48'h0);
    repeat (5 * HALF) @(negedge clk);
    check(pulses == 1 && frameData == 32'h01 && frameAddr == 16'h00,
          "R11 strobe after timeout", {frameAddr, frameData}, {16'h0, 32'h1});

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule